// File: doc/BRIEF.md
# Descriptor Prefetch Burst Arbiter

This block decides which of several descriptor queues fetches next, and how many descriptors that fetch asks for. All queues share one 1024-slot descriptor buffer. Each queue owns a slice of that buffer, defined by an 11-bit start slot and a 12-bit depth (128 is the usual depth). A queue can compete when its prefetch enable bit is set and its tail pointer is ahead of the block's internal head pointer for that queue. The block sizes a burst as the smallest of three values: the free space in the slice, the descriptors pending before the tail, and a maximum burst (8 by default).

A minimum-burst rule filters out wasteful small fetches. When the free space in the slice is above a programmable threshold (typically 16), the burst must reach a larger minimum (typically 4). At or below the threshold, a smaller minimum applies (typically 1). A per-queue override lets a queue issue a burst smaller than the minimum. Eligible queues are served in round-robin order when the rotate control is set, and in lowest-index-first order when it is clear.

The winning request leaves on a valid/ready channel. It carries the queue number, the descriptor count and the buffer slot where the burst lands. While valid is high and ready is low, the request holds unchanged. The queue's head pointer, slice write offset and occupancy update only on the handshake. After a handshake, valid drops for one cycle before the next request is offered.

A consumer returns slots one at a time through a per-queue consume pulse. The consume pulse also carries an end-of-packet flag. If a packet runs longer than a programmable descriptor limit (typically 64), the block raises a one-cycle error pulse for that queue.

Top module: `desc_pref_arbiter`

## Requirements
- R1: After reset, req_valid_o is 0, every occupancy reads 0, err_maxdesc_o is 0, and the prefetch enable mask holds all ones.
- R2: The count of a request equals the smallest of three values: the free slice space (depth minus occupancy, floored at 0), the pending count (tail minus internal head, modulo 2^PTR_W) and MAX_BURST. A request never carries a count of 0.
- R3: If the free space is greater than pref_thr_i, the minimum burst is burst_hi_i. Otherwise the minimum burst is burst_lo_i. A queue whose burst is below its minimum issues no request.
- R4: When allow_small_i[q] is 1, queue q issues any non-zero burst regardless of the minimum.
- R5: When force_rr_i is 1, the search for the next eligible queue starts at the queue after the last one granted, wrapping from NQ-1 to 0. The pointer starts at queue 0 after reset.
- R6: When force_rr_i is 0, the lowest-numbered eligible queue wins.
- R7: A queue whose mask bit is 0 issues no request, and its occupancy stays unchanged. The mask is loaded from mask_i on any cycle where mask_wr_i is 1.
- R8: req_slot_o equals (slice start + slice write offset) mod 1024. The write offset starts at 0, advances by each granted count, and wraps at the slice depth.
- R9: A queue's occupancy rises by the granted count on a handshake and falls by 1 on each consume pulse (never below 0). occ_o shows the occupancy of the queue selected by occ_sel_i.
- R10: While req_valid_o is 1 and req_ready_i is 0, req_valid_o, req_q_o, req_cnt_o and req_slot_o hold their values.
- R11: A consume pulse for queue q that is the N-th descriptor of its packet, with N greater than max_desc_i, sets err_maxdesc_o[q] to 1 for the following cycle. A consume pulse with consume_last_i set ends the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_wr_i | input | 1 | Load the prefetch enable mask |
| mask_i | input | NQ | New prefetch enable mask |
| force_rr_i | input | 1 | 1 = rotate among queues, 0 = lowest index first |
| pref_thr_i | input | 8 | Free-space threshold |
| burst_hi_i | input | 4 | Minimum burst above the threshold |
| burst_lo_i | input | 4 | Minimum burst at or below the threshold |
| max_desc_i | input | 12 | Longest allowed packet in descriptors |
| slice_start_i | input | NQ*11 | Per-queue slice start slot |
| slice_depth_i | input | NQ*12 | Per-queue slice depth |
| allow_small_i | input | NQ | Per-queue minimum-burst override |
| tail_i | input | NQ*PTR_W | Per-queue tail pointer |
| consume_i | input | NQ | Per-queue slot-return pulse |
| consume_last_i | input | NQ | End-of-packet flag of the returned slot |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted |
| req_q_o | output | $clog2(NQ) | Requesting queue |
| req_cnt_o | output | $clog2(MAX_BURST+1) | Descriptor count |
| req_slot_o | output | 10 | Buffer slot for the first descriptor |
| occ_sel_i | input | $clog2(NQ) | Queue chosen for occupancy readback |
| occ_o | output | 12 | Occupancy of the selected queue |
| err_maxdesc_o | output | NQ | Per-queue over-long-packet pulse |

## Verification
The bench targets the boundary between the two minimum-burst rules. A three-descriptor burst with ample free space must stay silent, and it must be issued once the override is set. A design that compared against the wrong minimum would issue it early or never. A narrow slice exercises the free-space limit and the wrap of the write offset to slot zero. A design with a bad wrap would send the burst past the end of the slice. Arbitration order is checked in both rotate and fixed-priority modes; swapped orders would put queue numbers in the scoreboard out of sequence. The bench also checks a masked queue, a stalled request held under back-pressure, and the fifth descriptor of a four-descriptor packet limit.

// File: rtl/pref_arb_pkg.sv
package pref_arb_pkg;
  localparam int BUF_SLOTS = 1024;
  localparam int SLOT_W    = $clog2(BUF_SLOTS);
  localparam int START_W   = 11;
  localparam int DEPTH_W   = 12;
  localparam int THR_W     = 8;
  localparam int BURST_W   = 4;
  localparam int PKT_W     = 12;
endpackage

// File: rtl/pref_q_slice.sv
module pref_q_slice
  import pref_arb_pkg::*;
#(
  parameter int PTR_W     = 16,
  parameter int CW        = 4,
  parameter int MAX_BURST = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               allow_small_i,
  input  logic [START_W-1:0] start_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic [PTR_W-1:0]   tail_i,
  input  logic [THR_W-1:0]   thr_i,
  input  logic [BURST_W-1:0] bhi_i,
  input  logic [BURST_W-1:0] blo_i,
  input  logic               take_i,
  input  logic [CW-1:0]      take_cnt_i,
  input  logic               consume_i,
  output logic               elig_o,
  output logic [CW-1:0]      size_o,
  output logic [SLOT_W-1:0]  slot_o,
  output logic [DEPTH_W-1:0] occ_o
);
  localparam int BW = (PTR_W > DEPTH_W) ? PTR_W : DEPTH_W;

  logic [PTR_W-1:0]   head_q;
  logic [DEPTH_W-1:0] occ_q, wptr_q;
  logic [PTR_W-1:0]   pend;
  logic [DEPTH_W-1:0] free_sp;
  logic [BW-1:0]      pend_w, free_w, lim_w, min_w;
  logic [DEPTH_W:0]   wsum, ssum;
  logic [DEPTH_W-1:0] wnext, occ_add, occ_nx;

  always_comb begin
    pend    = tail_i - head_q;
    free_sp = (depth_i > occ_q) ? depth_i - occ_q : '0;
    pend_w  = BW'(pend);
    free_w  = BW'(free_sp);
    lim_w   = BW'(MAX_BURST);
    if (free_w < lim_w) lim_w = free_w;
    if (pend_w < lim_w) lim_w = pend_w;
    min_w   = (free_w > BW'(thr_i)) ? BW'(bhi_i) : BW'(blo_i);
  end

  assign elig_o = en_i && (lim_w != '0) && (allow_small_i || (lim_w >= min_w));
  assign size_o = CW'(lim_w);

  always_comb begin
    wsum  = {1'b0, wptr_q} + (DEPTH_W+1)'(take_cnt_i);
    wnext = (wsum >= {1'b0, depth_i}) ? DEPTH_W'(wsum - {1'b0, depth_i}) : DEPTH_W'(wsum);
    ssum  = (DEPTH_W+1)'(start_i) + (DEPTH_W+1)'(wptr_q);
    occ_add = occ_q + (take_i ? DEPTH_W'(take_cnt_i) : '0);
    occ_nx  = (consume_i && (occ_add != '0)) ? occ_add - 1'b1 : occ_add;
  end

  assign slot_o = ssum[SLOT_W-1:0];
  assign occ_o  = occ_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      wptr_q <= '0;
      occ_q  <= '0;
    end else begin
      occ_q <= occ_nx;
      if (take_i) begin
        head_q <= head_q + PTR_W'(take_cnt_i);
        wptr_q <= wnext;
      end
    end
  end
endmodule

// File: rtl/pref_rr_pick.sv
module pref_rr_pick #(
  parameter int NQ = 16,
  parameter int QW = 4
) (
  input  logic [NQ-1:0] req_i,
  input  logic          rr_i,
  input  logic [QW-1:0] ptr_i,
  output logic          any_o,
  output logic [QW-1:0] win_o
);
  int idx;
  always_comb begin
    any_o = 1'b0;
    win_o = '0;
    idx   = 0;
    for (int off = 0; off < NQ; off++) begin
      idx = (rr_i ? int'(ptr_i) : 0) + off;
      if (idx >= NQ) idx = idx - NQ;
      if (!any_o && req_i[idx]) begin
        any_o = 1'b1;
        win_o = QW'(idx);
      end
    end
  end
endmodule

// File: rtl/pref_pkt_guard.sv
module pref_pkt_guard
  import pref_arb_pkg::*;
#(
  parameter int NQ = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NQ-1:0]    consume_i,
  input  logic [NQ-1:0]    last_i,
  input  logic [PKT_W-1:0] max_i,
  output logic [NQ-1:0]    err_o
);
  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic [PKT_W-1:0] run_q;
    logic [PKT_W:0]   nth;
    assign nth = {1'b0, run_q} + 1'b1;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run_q    <= '0;
        err_o[g] <= 1'b0;
      end else begin
        err_o[g] <= consume_i[g] && (nth > {1'b0, max_i});
        if (consume_i[g]) begin
          if (last_i[g])      run_q <= '0;
          else if (!nth[PKT_W]) run_q <= nth[PKT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/desc_pref_arbiter.sv
module desc_pref_arbiter
  import pref_arb_pkg::*;
#(
  parameter int NQ        = 16,
  parameter int PTR_W     = 16,
  parameter int MAX_BURST = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int CW = $clog2(MAX_BURST + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mask_wr_i,
  input  logic [NQ-1:0]         mask_i,
  input  logic                  force_rr_i,
  input  logic [THR_W-1:0]      pref_thr_i,
  input  logic [BURST_W-1:0]    burst_hi_i,
  input  logic [BURST_W-1:0]    burst_lo_i,
  input  logic [PKT_W-1:0]      max_desc_i,
  input  logic [NQ*START_W-1:0] slice_start_i,
  input  logic [NQ*DEPTH_W-1:0] slice_depth_i,
  input  logic [NQ-1:0]         allow_small_i,
  input  logic [NQ*PTR_W-1:0]   tail_i,
  input  logic [NQ-1:0]         consume_i,
  input  logic [NQ-1:0]         consume_last_i,
  output logic                  req_valid_o,
  input  logic                  req_ready_i,
  output logic [QW-1:0]         req_q_o,
  output logic [CW-1:0]         req_cnt_o,
  output logic [SLOT_W-1:0]     req_slot_o,
  input  logic [QW-1:0]         occ_sel_i,
  output logic [DEPTH_W-1:0]    occ_o,
  output logic [NQ-1:0]         err_maxdesc_o
);
  logic [NQ-1:0]      mask_q, elig, take;
  logic [CW-1:0]      size_a [NQ];
  logic [SLOT_W-1:0]  slot_a [NQ];
  logic [DEPTH_W-1:0] occ_a  [NQ];
  logic [QW-1:0]      rr_ptr_q, win;
  logic               any, hs;

  assign hs = req_valid_o && req_ready_i;

  for (genvar g = 0; g < NQ; g++) begin : g_slice
    assign take[g] = hs && (req_q_o == QW'(g));
    pref_q_slice #(.PTR_W(PTR_W), .CW(CW), .MAX_BURST(MAX_BURST)) u_slice (
      .clk           (clk),
      .rst_n         (rst_n),
      .en_i          (mask_q[g]),
      .allow_small_i (allow_small_i[g]),
      .start_i       (slice_start_i[g*START_W +: START_W]),
      .depth_i       (slice_depth_i[g*DEPTH_W +: DEPTH_W]),
      .tail_i        (tail_i[g*PTR_W +: PTR_W]),
      .thr_i         (pref_thr_i),
      .bhi_i         (burst_hi_i),
      .blo_i         (burst_lo_i),
      .take_i        (take[g]),
      .take_cnt_i    (req_cnt_o),
      .consume_i     (consume_i[g]),
      .elig_o        (elig[g]),
      .size_o        (size_a[g]),
      .slot_o        (slot_a[g]),
      .occ_o         (occ_a[g])
    );
  end

  pref_rr_pick #(.NQ(NQ), .QW(QW)) u_pick (
    .req_i (elig),
    .rr_i  (force_rr_i),
    .ptr_i (rr_ptr_q),
    .any_o (any),
    .win_o (win)
  );

  pref_pkt_guard #(.NQ(NQ)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .consume_i (consume_i),
    .last_i    (consume_last_i),
    .max_i     (max_desc_i),
    .err_o     (err_maxdesc_o)
  );

  assign occ_o = occ_a[occ_sel_i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q      <= '1;
      rr_ptr_q    <= '0;
      req_valid_o <= 1'b0;
      req_q_o     <= '0;
      req_cnt_o   <= '0;
      req_slot_o  <= '0;
    end else begin
      if (mask_wr_i) mask_q <= mask_i;
      if (hs) begin
        req_valid_o <= 1'b0;
        rr_ptr_q    <= (req_q_o == QW'(NQ - 1)) ? '0 : req_q_o + 1'b1;
      end else if (!req_valid_o && any) begin
        req_valid_o <= 1'b1;
        req_q_o     <= win;
        req_cnt_o   <= size_a[win];
        req_slot_o  <= slot_a[win];
      end
    end
  end
endmodule

// File: rtl/desc_pref_arbiter_chk.sv
module desc_pref_arbiter_chk #(
  parameter int NQ = 16,
  parameter int QW = 4,
  parameter int CW = 4,
  parameter int MAX_BURST = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid_o,
  input logic          req_ready_i,
  input logic [QW-1:0] req_q_o,
  input logic [CW-1:0] req_cnt_o,
  input logic [9:0]    req_slot_o,
  input logic [NQ-1:0] mask_q,
  input logic [NQ-1:0] consume_i,
  input logic [NQ-1:0] err_maxdesc_o,
  input logic [QW-1:0] occ_sel_i,
  input logic [11:0]   occ_o
);
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_q_o) && $stable(req_cnt_o) && $stable(req_slot_o))); // R10

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_cnt_o != '0 && int'(req_cnt_o) <= MAX_BURST)); // R2

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid_o) |-> ((($past(mask_q) >> req_q_o) & NQ'(1)) != '0)); // R7

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_maxdesc_o & ~$past(consume_i)) == '0); // R11

  AST_OCC_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(occ_sel_i) && occ_o > $past(occ_o)) |->
      $past(req_valid_o && req_ready_i && req_q_o == occ_sel_i)); // R9
endmodule

bind desc_pref_arbiter desc_pref_arbiter_chk #(.NQ(NQ), .QW(QW), .CW(CW), .MAX_BURST(MAX_BURST)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid_o   (req_valid_o),
  .req_ready_i   (req_ready_i),
  .req_q_o       (req_q_o),
  .req_cnt_o     (req_cnt_o),
  .req_slot_o    (req_slot_o),
  .mask_q        (mask_q),
  .consume_i     (consume_i),
  .err_maxdesc_o (err_maxdesc_o),
  .occ_sel_i     (occ_sel_i),
  .occ_o         (occ_o)
);

// File: tb/desc_pref_arbiter_bench.sv
`timescale 1ns/1ps
module desc_pref_arbiter_bench;
  localparam int NQ = 16;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          mask_wr = 1'b0;
  logic [NQ-1:0] mask_v = '1;
  logic          force_rr = 1'b1;
  logic [7:0]    thr = 8'd16;
  logic [3:0]    bhi = 4'd4, blo = 4'd1;
  logic [11:0]   maxd = 12'd64;
  logic [10:0]   start_a [NQ];
  logic [11:0]   depth_a [NQ];
  logic [PW-1:0] tail_a  [NQ];
  logic [NQ-1:0] allow = '0, cons = '0, cons_last = '0;
  logic          ready = 1'b1;
  logic [3:0]    occ_sel = '0;
  logic [NQ*11-1:0] start_v;
  logic [NQ*12-1:0] depth_v;
  logic [NQ*PW-1:0] tail_v;
  logic          req_valid;
  logic [3:0]    req_q, req_cnt;
  logic [9:0]    req_slot;
  logic [11:0]   occ;
  logic [NQ-1:0] err;

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      start_v[q*11 +: 11] = start_a[q];
      depth_v[q*12 +: 12] = depth_a[q];
      tail_v[q*PW +: PW]  = tail_a[q];
    end
  end

  desc_pref_arbiter u_desc_pref_arbiter (
    .clk(clk), .rst_n(rst_n), .mask_wr_i(mask_wr), .mask_i(mask_v),
    .force_rr_i(force_rr), .pref_thr_i(thr), .burst_hi_i(bhi), .burst_lo_i(blo),
    .max_desc_i(maxd), .slice_start_i(start_v), .slice_depth_i(depth_v),
    .allow_small_i(allow), .tail_i(tail_v), .consume_i(cons), .consume_last_i(cons_last),
    .req_valid_o(req_valid), .req_ready_i(ready), .req_q_o(req_q), .req_cnt_o(req_cnt),
    .req_slot_o(req_slot), .occ_sel_i(occ_sel), .occ_o(occ), .err_maxdesc_o(err)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  typedef struct { int q; int cnt; int slot; string tag; } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_req(input int q, input int cnt, input int slot, input string tag);
    exp_t e;
    e.q = q; e.cnt = cnt; e.slot = slot; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare every accepted request with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && req_valid && ready) begin
      if (sb.size() == 0) chk(1'b0, "unexpected request queue", int'(req_q), -1);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(int'(req_q) == e.q, {e.tag, " queue"}, int'(req_q), e.q);
        chk(int'(req_cnt) == e.cnt, {e.tag, " count"}, int'(req_cnt), e.cnt);
        chk(int'(req_slot) == e.slot, {e.tag, " slot"}, int'(req_slot), e.slot);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain(input string tag);
    int w = 0;
    while (sb.size() != 0 && w < 60) begin step(1); w++; end
    step(3);
    chk(sb.size() == 0, {tag, " drained"}, sb.size(), 0);
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!req_valid, tag, int'(req_valid), 0);
    end
    step(1);
  endtask

  task automatic occ_is(input int q, input int exp, input string tag);
    occ_sel = 4'(q);
    @(negedge clk);
    chk(int'(occ) == exp, tag, int'(occ), exp);
    step(1);
  endtask

  task automatic consume(input int q, input bit last);
    cons[q] = 1'b1; cons_last[q] = last;
    step(1);
    cons = '0; cons_last = '0;
  endtask

  task automatic load_mask(input logic [NQ-1:0] m);
    mask_v = m; mask_wr = 1'b1;
    step(1);
    mask_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int q = 0; q < NQ; q++) begin
      start_a[q] = 11'(q * 64); depth_a[q] = 12'd128; tail_a[q] = '0;
    end
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!req_valid, "R1 valid after reset", int'(req_valid), 0);
    chk(occ == 0, "R1 occupancy after reset", int'(occ), 0);
    chk(err == 0, "R1 error after reset", int'(err), 0);
    step(1);

    // R2 size limited by max burst, then by pending; R8 slot progression
    expect_req(3, 8, 192, "R2 first burst");
    expect_req(3, 8, 200, "R2 second burst");
    expect_req(3, 4, 208, "R2 pending-limited R8");
    tail_a[3] = 16'd20;
    drain("R2");
    occ_is(3, 20, "R9 occupancy after grants");

    // R5 round robin continues after queue 3
    expect_req(5, 8, 320, "R5 rotate first");
    expect_req(1, 8, 64, "R5 rotate wrap");
    tail_a[1] = 16'd8; tail_a[5] = 16'd8;
    drain("R5");

    // R3 burst of 3 with ample space is withheld
    tail_a[4] = 16'd3;
    quiet(6, "R3 small burst withheld");
    // R3 narrow slice: free 10 at/below threshold uses minimum 1
    depth_a[2] = 12'd10;
    expect_req(2, 3, 128, "R3 low minimum");
    tail_a[2] = 16'd3;
    drain("R3");
    // R4 override releases the withheld burst
    expect_req(4, 3, 256, "R4 override");
    allow[4] = 1'b1;
    drain("R4");
    allow[4] = 1'b0;

    // R2 free-space limit in narrow slice
    expect_req(2, 7, 131, "R2 free-limited");
    tail_a[2] = 16'd23;
    drain("R2 free");
    // R7 mask queue 2 while returning two slots, R8 offset wraps to slice start
    load_mask(~(NQ'(1) << 2));
    consume(2, 1'b0);
    consume(2, 1'b1);
    quiet(3, "R7 masked queue 2 silent");
    occ_is(2, 8, "R9 occupancy after consumes");
    expect_req(2, 2, 128, "R8 wrap to start");
    load_mask('1);
    drain("R8");
    occ_is(2, 10, "R9 occupancy slice full");

    // R7 masked queue keeps occupancy untouched
    load_mask(~(NQ'(1) << 6));
    tail_a[6] = 16'd8;
    quiet(6, "R7 masked queue 6 silent");
    occ_is(6, 0, "R7 masked occupancy");
    expect_req(6, 8, 384, "R7 unmasked");
    load_mask('1);
    drain("R7");

    // R6 fixed priority, R10 stall hold
    force_rr = 1'b0;
    ready = 1'b0;
    expect_req(0, 8, 0, "R6 lowest first");
    expect_req(7, 8, 448, "R6 next");
    tail_a[0] = 16'd8; tail_a[7] = 16'd8;
    step(3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(req_valid && req_q == 4'd0, "R10 held queue", int'(req_q), 0);
      chk(req_cnt == 4'd8 && req_slot == 10'd0, "R10 held payload", int'(req_cnt), 8);
    end
    step(1);
    ready = 1'b1;
    drain("R6");

    // R11 packet length limit of 4
    maxd = 12'd4;
    for (int i = 1; i <= 5; i++) begin
      consume(3, 1'b0);
      @(negedge clk);
      chk(err[3] == (i == 5), "R11 error on fifth descriptor", int'(err[3]), int'(i == 5));
    end
    step(1);
    consume(3, 1'b1);
    consume(3, 1'b0);
    @(negedge clk);
    chk(err == 0, "R11 count restarts after last", int'(err), 0);
    step(1);
    occ_is(3, 13, "R9 occupancy after returns");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule